// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both an attached storage drive and its host controller can run. It looks at the drive's identify-data capability fields (UltraDMA, multi-word and single-word support bytes, the field-valid word and a legacy single-word timing value), at the host's own support masks for each class, and at whether an 80-conductor cable was detected. It also looks at whether the device is a disk, and, if it is not, at whether DMA is allowed for packet devices.

Software or a configuration sequencer pulses `start` once the inputs are stable. One clock later the block presents an encoded mode byte together with a one-cycle valid pulse. The mode byte is a class base plus the index of the fastest mode in that class. A mode byte of zero means that no DMA mode can be used and the device should stay on programmed I/O.

Top module: `dma_mode_pick`

## Requirements
- R1: After reset, `mode_code` is 0x00 and `mode_valid` is 0.
- R2: `mode_valid` is 1 in exactly the cycle after a cycle with `start` high, and 0 otherwise. `mode_code` changes only in the cycle after `start`; otherwise it holds its value.
- R3: Classes are tried in this order: UltraDMA, then multi-word DMA, then single-word DMA. The first class whose effective mask is nonzero decides the result, even when a later class has a higher index.
- R4: The code is the base of the winning class plus the bit index of the highest set bit of its effective mask. The bases are 0x40 for UltraDMA, 0x20 for multi-word and 0x10 for single-word.
- R5: The UltraDMA effective mask is `udma_cap & host_udma_mask`. It is used only when bit 2 of `id_field_valid` is 1; otherwise it is zero.
- R6: If the UltraDMA mask has any bit in 0x78 set and `cable_80w` is 0, the mask is cut to its bits 2..0 (AND 0x07). With `cable_80w` set, no cut is made.
- R7: The multi-word mask is `mw_cap & host_mw_mask` and the single-word mask is `sw_cap & host_sw_mask`. Both are used only when bit 1 of `id_field_valid` is 1.
- R8: When bit 1 of `id_field_valid` is 0 and `sw_timing` is 1 or 2, the single-word mask is `((2 << sw_timing) - 1) & host_sw_mask`. Any other `sw_timing` value gives a zero single-word mask.
- R9: When `is_disk` is 0 and `atapi_dma_ok` is 0, the code is 0x00, whatever the other inputs are.
- R10: When every effective mask is zero, the code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the inputs and register a result |
| is_disk | input | 1 | Device is a disk (not a packet device) |
| atapi_dma_ok | input | 1 | DMA allowed for non-disk devices |
| cable_80w | input | 1 | 80-conductor cable detected |
| id_field_valid | input | 16 | Identify field-valid word (bit 1: DMA words valid, bit 2: UltraDMA word valid) |
| udma_cap | input | 8 | Drive UltraDMA support bits |
| mw_cap | input | 8 | Drive multi-word DMA support bits |
| sw_cap | input | 8 | Drive single-word DMA support bits |
| sw_timing | input | 8 | Legacy single-word timing mode value |
| host_udma_mask | input | 8 | Host UltraDMA mode mask |
| host_mw_mask | input | 8 | Host multi-word mode mask |
| host_sw_mask | input | 8 | Host single-word mode mask |
| mode_code | output | 8 | Selected mode code, 0x00 when no DMA |
| mode_valid | output | 1 | One-cycle pulse when a new code is presented |

## Verification
Random capability and mask patterns, with the validity bits, the cable flag and the device type drawn independently, exercise the class priority and the highest-bit encoding. Each result is compared with a reference model in the bench. Directed cases test the boundaries that random draws rarely reach:
- UltraDMA masks with only the low three bits set, which show that the cable cut leaves them alone.
- A mask with only bit 7 set, which shows that the cut keeps a bit outside 0x78.
- A later class with a higher index than the winning class, which separates priority order from "highest overall".
- Legacy timing values 0 through 3, which separate the derived single-word mask from the identify-word mask.
- A non-disk device with packet DMA forbidden, which must return zero even with full masks.

// File: rtl/dma_mode_pick.sv
module dma_mode_pick #(
  parameter int MW = 8,
  parameter logic [7:0] UDMA_BASE = 8'h40,
  parameter logic [7:0] MWDMA_BASE = 8'h20,
  parameter logic [7:0] SWDMA_BASE = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_disk,
  input  logic          atapi_dma_ok,
  input  logic          cable_80w,
  input  logic [15:0]   id_field_valid,
  input  logic [MW-1:0] udma_cap,
  input  logic [MW-1:0] mw_cap,
  input  logic [MW-1:0] sw_cap,
  input  logic [7:0]    sw_timing,
  input  logic [MW-1:0] host_udma_mask,
  input  logic [MW-1:0] host_mw_mask,
  input  logic [MW-1:0] host_sw_mask,
  output logic [7:0]    mode_code,
  output logic          mode_valid
);
  localparam logic [MW-1:0] FAST_BITS = MW'(8'h78);
  localparam logic [MW-1:0] SLOW_BITS = MW'(8'h07);

  function automatic logic [7:0] top_bit(input logic [MW-1:0] m);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < MW; i++)
      if (m[i]) r = 8'(i);
    return r;
  endfunction

  logic [MW-1:0] u_raw, u_eff, mw_eff, sw_eff, legacy;
  logic          legacy_ok, allowed;
  logic [7:0]    next_code;

  assign u_raw  = id_field_valid[2] ? (udma_cap & host_udma_mask) : '0;
  assign u_eff  = ((|(u_raw & FAST_BITS)) && !cable_80w) ? (u_raw & SLOW_BITS) : u_raw;
  assign mw_eff = id_field_valid[1] ? (mw_cap & host_mw_mask) : '0;

  assign legacy_ok = (sw_timing != 8'd0) && (sw_timing <= 8'd2);
  assign legacy    = MW'((4'd2 << sw_timing[1:0]) - 4'd1);
  assign sw_eff    = id_field_valid[1] ? (sw_cap & host_sw_mask)
                   : legacy_ok ? (legacy & host_sw_mask) : '0;

  assign allowed = is_disk || atapi_dma_ok;

  always_comb begin
    next_code = 8'h00;
    if (allowed) begin
      if (|u_eff)       next_code = UDMA_BASE + top_bit(u_eff);
      else if (|mw_eff) next_code = MWDMA_BASE + top_bit(mw_eff);
      else if (|sw_eff) next_code = SWDMA_BASE + top_bit(sw_eff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_code  <= 8'h00;
      mode_valid <= 1'b0;
    end else begin
      mode_valid <= start;
      if (start) mode_code <= next_code;
    end
  end

  // R2
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mode_valid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !mode_valid);
  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mode_code));
  // R9
  nondisk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_disk && !atapi_dma_ok) |=> (mode_code == 8'h00));
  // R6
  cable_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cable_80w) |=> !(mode_code >= 8'h43 && mode_code <= 8'h46));
  // R4
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_code[7:4]));
endmodule

// File: tb/sim_dma_mode_pick.sv
module sim_dma_mode_pick;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic is_disk = 1'b1, atapi_dma_ok = 1'b0, cable_80w = 1'b0;
  logic [15:0] fv = '0;
  logic [7:0] ucap = '0, mcap = '0, scap = '0, stim = '0, hu = '0, hm = '0, hs = '0;
  logic [7:0] mode_code;
  logic mode_valid;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_mode_pick u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_disk(is_disk),
    .atapi_dma_ok(atapi_dma_ok), .cable_80w(cable_80w), .id_field_valid(fv),
    .udma_cap(ucap), .mw_cap(mcap), .sw_cap(scap), .sw_timing(stim),
    .host_udma_mask(hu), .host_mw_mask(hm), .host_sw_mask(hs),
    .mode_code(mode_code), .mode_valid(mode_valid));

  function automatic int hi_idx(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] ref_code();
    logic [7:0] u, mw, sw;
    if (!is_disk && !atapi_dma_ok) return 8'h00;
    u = fv[2] ? (ucap & hu) : 8'h00;
    if ((u & 8'h78) != 0 && !cable_80w) u = u & 8'h07;
    mw = fv[1] ? (mcap & hm) : 8'h00;
    if (fv[1]) sw = scap & hs;
    else if (stim == 8'd1) sw = 8'h03 & hs;
    else if (stim == 8'd2) sw = 8'h07 & hs;
    else sw = 8'h00;
    if (u != 0) return 8'h40 + 8'(hi_idx(u));
    if (mw != 0) return 8'h20 + 8'(hi_idx(mw));
    if (sw != 0) return 8'h10 + 8'(hi_idx(sw));
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic run(input string req);
    logic [7:0] exp, held;
    exp = ref_code();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(req, {7'd0, mode_valid}, 8'h01);
    check(req, mode_code, exp);
    held = mode_code;
    ucap = ~ucap; mcap = ~mcap; hu = ~hu;
    @(negedge clk);
    check("R2 valid drop", {7'd0, mode_valid}, 8'h00);
    check("R2 hold", mode_code, held);
  endtask

  task automatic setup(input logic [15:0] f, input logic [7:0] u, input logic [7:0] m,
                       input logic [7:0] s, input logic [7:0] t, input logic c);
    fv = f; ucap = u; mcap = m; scap = s; stim = t; cable_80w = c;
    hu = 8'hFF; hm = 8'hFF; hs = 8'hFF; is_disk = 1'b1; atapi_dma_ok = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 code", mode_code, 8'h00);
    check("R1 valid", {7'd0, mode_valid}, 8'h00);
    rst_n = 1'b1;

    setup(16'h0006, 8'h3F, 8'h07, 8'h07, 0, 1'b1); run("R4 R5 udma5 80w");
    setup(16'h0006, 8'h3F, 8'h07, 8'h07, 0, 1'b0); run("R6 cut to udma2");
    setup(16'h0006, 8'h07, 8'h00, 8'h00, 0, 1'b0); run("R6 low bits untouched");
    setup(16'h0006, 8'h80, 8'h00, 8'h00, 0, 1'b0); run("R6 bit7 kept");
    setup(16'h0002, 8'h3F, 8'h01, 8'h07, 0, 1'b1); run("R5 no udma without bit2");
    setup(16'h0006, 8'h01, 8'h07, 8'h07, 0, 1'b1); run("R3 udma0 beats mw2");
    setup(16'h0006, 8'h00, 8'h02, 8'h04, 0, 1'b1); run("R3 mw1 beats sw2");
    setup(16'h0004, 8'h00, 8'h07, 8'h07, 0, 1'b1); run("R7 no mw sw without bit1");
    for (int t = 0; t < 4; t++) begin
      setup(16'h0000, 8'h00, 8'h00, 8'h00, 8'(t), 1'b1); run("R8 legacy timing");
    end
    setup(16'h0000, 8'h00, 8'h00, 8'h00, 8'd2, 1'b1); hs = 8'h03; run("R8 legacy host masked");
    setup(16'h0002, 8'h00, 8'h00, 8'h01, 8'd2, 1'b1); run("R8 identify word wins");
    setup(16'h0006, 8'hFF, 8'hFF, 8'hFF, 8'd2, 1'b1); is_disk = 1'b0; run("R9 non-disk blocked");
    setup(16'h0006, 8'hFF, 8'hFF, 8'hFF, 8'd2, 1'b1); is_disk = 1'b0; atapi_dma_ok = 1'b1; run("R9 non-disk allowed");
    setup(16'h0006, 8'h0F, 8'h07, 8'h07, 0, 1'b1); hu = 0; hm = 0; hs = 0; run("R10 nothing common");

    for (int n = 0; n < 400; n++) begin
      fv = 16'($urandom);
      ucap = 8'($urandom); mcap = 8'($urandom); scap = 8'($urandom);
      if ($urandom % 2) ucap = ucap & 8'($urandom);
      stim = 8'($urandom % 4);
      hu = 8'($urandom); hm = 8'($urandom); hs = 8'($urandom);
      cable_80w = 1'($urandom); is_disk = 1'($urandom); atapi_dma_ok = 1'($urandom);
      run("R3 R4 R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule